// File: doc/BRIEF.md
# Set-Associative Cache with Separate Tag Arrays

This block is a conventional set-associative data cache in which every way is its own bank, with a private tag array beside a private data array. A processor-side port takes one 32-bit load or store at a time and answers with a response strobe, a hit flag and the read word. A `stall` output tells the processor when a new request cannot be taken. A refill port on the memory side asks for a missing line by its aligned address and then accepts the line as eight 32-bit words.

Loads run in one of two ways, chosen per request by a mode input.
- **Parallel load:** the tags and the addressed word of every way are read together, and the tag compares then pick the data.
- **Two-phase load:** only the tags are read first, and then only the matching way's data bank is read. This saves data-bank reads at the cost of one cycle.

A store always checks the tag in one cycle and writes the word in the next. The store writes only when the tag hit, and a store miss does not allocate a line. A load miss refills a victim way, which is chosen by a round-robin pointer kept for each set, and then replays the lookup.

The way count can be 1, 2, 4 or 8. Each way holds 32 sets of 32-byte lines, so the capacity is 1 KB per way. With one way the data path has no select mux, and the stored word is forwarded while the hit flag qualifies it.

Top module: `ram_tag_cache`

## Requirements
- R1: After reset every entry is invalid, and `stall`, `rsp_valid` and `fill_req` are low; the first load to any address misses.
- R2: Address fields: word select is addr[4:2], set index is addr[9:5], tag is addr[31:10]; addr[1:0] has no effect on which word is returned.
- R3: A parallel-mode load accepted in cycle t that hits gives `rsp_valid`=1, `rsp_hit`=1 and the stored word in cycle t+1. In that cycle `stall` is low, so a request held on the port is accepted in the same cycle.
- R4: A two-phase load accepted in cycle t that hits holds `stall` high in cycle t+1 and gives the response in cycle t+2. At most one data bank is read for it.
- R5: A store accepted in cycle t raises `stall` and `rsp_valid` in cycle t+1, with `rsp_hit` giving the tag result. The word is written only on a hit; a store miss leaves the cache unchanged and allocates nothing.
- R6: A load miss raises `fill_req`, with `fill_addr` equal to the request address with bits [4:0] cleared, from the cycle after the failed compare. Refill word k written with `fill_valid` lands at word offset k.
- R7: The refill ends with the eighth accepted word. The load is then replayed, and it responds as a hit 2 cycles (parallel) or 3 cycles (two-phase) after the cycle that carried the eighth word.
- R8: Victim ways are chosen per set in round-robin order, starting at way 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_phase | input | 1 | Load mode for the offered request: 1 = tags first, 0 = parallel |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| stall | output | 1 | Request cannot be accepted this cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Tag hit for the response |
| rsp_rdata | output | 32 | Load data |
| fill_req | output | 1 | Refill in progress, line wanted |
| fill_addr | output | 32 | Line-aligned refill address |
| fill_valid | input | 1 | Refill word present |
| fill_data | input | 32 | Refill word, in ascending word order |

## Verification
Two things can happen in one cycle here: a parallel-mode load returns its hit response while the next request is taken on the same port. The bench provokes this by keeping `req_valid` high across the response cycle with a new address. It then judges that both words come back, one cycle apart, and that `stall` stays low in between. The last refill word and the tag install also share an edge, and the replay that follows must already see the new tag. This is judged by where the hit response falls after the eighth word.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_DATA,
    ST_FILL,
    ST_REPLAY
  } ctl_state_e;
endpackage

// File: rtl/rtc_tag_way.sv
module rtc_tag_way #(
  parameter int SETS  = 32,
  parameter int IDX_W = 5,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             hit
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vld;
  logic [TAG_W-1:0] tag_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) tag_q <= tag_mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      if (rd_en) vld_q <= vld[rd_idx];
    end
  end

  assign hit = vld_q && (tag_q == cmp_tag);
endmodule

// File: rtl/rtc_data_way.sv
module rtc_data_way #(
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 5,
  parameter int WSEL_W     = 3
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int DEPTH = SETS * LINE_WORDS;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_idx, wr_word}] <= wr_data;
    if (rd_en) rd_data <= mem[{rd_idx, rd_word}];
  end
endmodule

// File: rtl/ram_tag_cache.sv
module ram_tag_cache
  import rtc_pkg::*;
#(
  parameter int WAYS       = 2,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_phase,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              stall,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [WORD_W-1:0] fill_data
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFS_W  = WSEL_W + 2;
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
  localparam int VW     = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);
  localparam logic [VW-1:0]     LAST_WAY  = VW'(WAYS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  ctl_state_e         state_q, state_d;
  logic [ADDR_W-1:2]  a_q;
  logic [WORD_W-1:0]  wd_q;
  logic               we_q, two_q;
  logic [WSEL_W-1:0]  cnt_q;
  logic [WAYS-1:0]    sel_q;
  logic [VW-1:0]      rr_q [SETS];

  logic [WAYS-1:0]    hit_w, sel_src, d_rd_en, d_wr_en, t_wr_en;
  logic [WORD_W-1:0]  rdata_w [WAYS];
  logic               any_hit, accept, dread_hit, install;
  logic               unused_lsb;

  logic [IDX_W-1:0]   a_idx, r_idx, rd_idx;
  logic [WSEL_W-1:0]  a_word, r_word, rd_word, wr_word;
  logic [TAG_W-1:0]   a_tag;
  logic [VW-1:0]      victim;
  logic [WORD_W-1:0]  wr_data;

  assign unused_lsb = ^req_addr[1:0];
  assign a_word  = a_q[OFS_W-1:2];
  assign a_idx   = a_q[OFS_W +: IDX_W];
  assign a_tag   = a_q[ADDR_W-1 -: TAG_W];
  assign r_word  = req_addr[OFS_W-1:2];
  assign r_idx   = req_addr[OFS_W +: IDX_W];
  assign rd_idx  = accept ? r_idx  : a_idx;
  assign rd_word = accept ? r_word : a_word;
  assign victim  = rr_q[a_idx];
  assign any_hit = |hit_w;
  assign install = (state_q == ST_FILL) && fill_valid && (cnt_q == LAST_WORD);
  assign wr_word = (state_q == ST_FILL) ? cnt_q : a_word;
  assign wr_data = (state_q == ST_FILL) ? fill_data : wd_q;
  assign fill_req  = (state_q == ST_FILL);
  assign fill_addr = {a_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  // next-state and port control
  always_comb begin
    state_d   = state_q;
    stall     = 1'b1;
    rsp_valid = 1'b0;
    rsp_hit   = 1'b0;
    dread_hit = 1'b0;
    sel_src   = hit_w;
    unique case (state_q)
      ST_IDLE: stall = 1'b0;
      ST_TAG: begin
        if (we_q) begin
          rsp_valid = 1'b1;
          rsp_hit   = any_hit;
          state_d   = ST_IDLE;
        end else if (!any_hit) begin
          state_d = ST_FILL;
        end else if (two_q) begin
          dread_hit = 1'b1;
          state_d   = ST_DATA;
        end else begin
          rsp_valid = 1'b1;
          rsp_hit   = 1'b1;
          stall     = 1'b0;
          state_d   = ST_IDLE;
        end
      end
      ST_DATA: begin
        rsp_valid = 1'b1;
        rsp_hit   = 1'b1;
        stall     = 1'b0;
        sel_src   = sel_q;
        state_d   = ST_IDLE;
      end
      ST_FILL:   if (install) state_d = ST_REPLAY;
      ST_REPLAY: state_d = ST_TAG;
      default:   state_d = ST_IDLE;
    endcase
    accept = req_valid && !stall;
    if (accept) state_d = ST_TAG;
  end

  // per-way enables
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      d_rd_en[w] = (accept && !req_write && !two_phase) ||
                   ((state_q == ST_REPLAY) && !two_q) ||
                   (dread_hit && hit_w[w]);
      d_wr_en[w] = ((state_q == ST_TAG) && we_q && hit_w[w]) ||
                   ((state_q == ST_FILL) && fill_valid && (victim == VW'(w)));
      t_wr_en[w] = install && (victim == VW'(w));
    end
  end

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_way
      rtc_tag_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
        .clk(clk), .rst_n(rst_int_n),
        .rd_en(accept || (state_q == ST_REPLAY)), .rd_idx(rd_idx),
        .wr_en(t_wr_en[g]), .wr_idx(a_idx), .wr_tag(a_tag),
        .cmp_tag(a_tag), .hit(hit_w[g])
      );
      rtc_data_way #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W),
                     .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
        .clk(clk),
        .rd_en(d_rd_en[g]), .rd_idx(rd_idx), .rd_word(rd_word), .rd_data(rdata_w[g]),
        .wr_en(d_wr_en[g]), .wr_idx(a_idx), .wr_word(wr_word), .wr_data(wr_data)
      );
    end
    if (WAYS == 1) begin : g_dm
      // direct-mapped: word forwarded, hit only qualifies it
      assign rsp_rdata = rdata_w[0];
    end else begin : g_mux
      always_comb begin
        rsp_rdata = '0;
        for (int w = 0; w < WAYS; w++)
          if (sel_src[w]) rsp_rdata = rsp_rdata | rdata_w[w];
      end
    end
  endgenerate

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      two_q   <= 1'b0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q  <= req_write;
        two_q <= two_phase;
      end
      if ((state_q == ST_FILL) && fill_valid) cnt_q <= cnt_q + 1'b1;
      if (install) rr_q[a_idx] <= (victim == LAST_WAY) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      a_q  <= req_addr[ADDR_W-1:2];
      wd_q <= req_wdata;
    end
    if (state_q == ST_TAG) sel_q <= hit_w;
  end

  // assertions
  a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_TAG) |-> $onehot0(hit_w));
  a_r4_one_bank_read: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_TAG && two_q && !we_q) |-> $onehot0(d_rd_en));
  a_r4_second_cycle_resp: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_TAG && two_q && !we_q && any_hit) |=> (rsp_valid && rsp_hit));
  a_r5_store_second_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && req_write) |=> (stall && rsp_valid));
  a_r5_no_write_on_miss: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_TAG && we_q && !any_hit) |-> !(|d_wr_en));
  a_r3_parallel_next_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !req_write && !two_phase) |=> (rsp_valid || stall));
  a_r7_replay_after_last: assert property (@(posedge clk) disable iff (!rst_int_n)
    install |=> (state_q == ST_REPLAY && !fill_req));
endmodule

// File: tb/ram_tag_cache_tb.sv
module ram_tag_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        two_phase, req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        stall, rsp_valid, rsp_hit;
  logic [31:0] rsp_rdata;
  logic        fill_req;
  logic [31:0] fill_addr;
  logic        fill_valid;
  logic [31:0] fill_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  ram_tag_cache u_dut (
    .clk(clk), .rst_n(rst_n), .two_phase(two_phase),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .stall(stall), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .fill_req(fill_req),
    .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // serve a refill at the current negedge (FILL cycle), return at the REPLAY cycle
  task automatic serve_fill(input logic [31:0] line);
    check("R6", "fill_req", {31'b0, fill_req}, 32'd1);
    check("R6", "fill_addr", fill_addr, line);
    for (int k = 0; k < 8; k++) begin
      fill_valid = 1'b1;
      fill_data  = pat(line + 32'(4 * k));
      @(negedge clk);
    end
    fill_valid = 1'b0;
    check("R7", "no response in replay", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic load(input logic [31:0] a, input bit two, input bit exp_miss,
                      input logic [31:0] exp_data, input string rq);
    @(negedge clk);
    check(rq, "stall before accept", {31'b0, stall}, 32'd0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; two_phase = two;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_miss) begin
      check("R6", "miss no response", {31'b0, rsp_valid}, 32'd0);
      check("R6", "miss stall", {31'b0, stall}, 32'd1);
      @(negedge clk);
      serve_fill({a[31:5], 5'b0});
      @(negedge clk);
      if (two) begin
        check("R7", "two-phase replay waits", {31'b0, rsp_valid}, 32'd0);
        @(negedge clk);
      end
      check("R7", "replay hit", {30'b0, rsp_valid, rsp_hit}, 32'd3);
      check("R7", "replay data", rsp_rdata, exp_data);
    end else if (two) begin
      check("R4", "phase one no response", {31'b0, rsp_valid}, 32'd0);
      check("R4", "phase one stall", {31'b0, stall}, 32'd1);
      @(negedge clk);
      check(rq, "two-phase hit", {30'b0, rsp_valid, rsp_hit}, 32'd3);
      check(rq, "two-phase data", rsp_rdata, exp_data);
    end else begin
      check(rq, "parallel hit", {30'b0, rsp_valid, rsp_hit}, 32'd3);
      check(rq, "parallel data", rsp_rdata, exp_data);
      check("R3", "no stall on hit", {31'b0, stall}, 32'd0);
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input bit exp_hit);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; two_phase = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5", "store second cycle stall", {31'b0, stall}, 32'd1);
    check("R5", "store response", {30'b0, rsp_valid, rsp_hit}, {30'b0, 1'b1, exp_hit});
    @(negedge clk);
    check("R5", "store done", {31'b0, stall}, 32'd0);
  endtask

  task automatic test_reset();
    check("R1", "stall after reset", {31'b0, stall}, 32'd0);
    check("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    check("R1", "fill_req after reset", {31'b0, fill_req}, 32'd0);
  endtask

  task automatic test_basic_loads();
    load(32'h0000_1044, 1'b0, 1'b1, pat(32'h0000_1044), "R1");
    load(32'h0000_1047, 1'b0, 1'b0, pat(32'h0000_1044), "R2");
    load(32'h0000_105C, 1'b1, 1'b0, pat(32'h0000_105C), "R4");
    load(32'h0000_2088, 1'b1, 1'b1, pat(32'h0000_2088), "R4");
  endtask

  task automatic test_stores();
    store(32'h0000_1048, 32'hDEAD_BEEF, 1'b1);
    load(32'h0000_1048, 1'b0, 1'b0, 32'hDEAD_BEEF, "R5");
    store(32'h0000_3000, 32'h1234_5678, 1'b0);
    load(32'h0000_3000, 1'b0, 1'b1, pat(32'h0000_3000), "R5");
  endtask

  task automatic test_round_robin();
    load(32'h0000_40E0, 1'b0, 1'b1, pat(32'h0000_40E0), "R8");
    load(32'h0000_80E0, 1'b0, 1'b1, pat(32'h0000_80E0), "R8");
    load(32'h0000_C0E0, 1'b0, 1'b1, pat(32'h0000_C0E0), "R8");
    load(32'h0000_80E4, 1'b0, 1'b0, pat(32'h0000_80E4), "R8");
    load(32'h0000_40E0, 1'b0, 1'b1, pat(32'h0000_40E0), "R8");
    load(32'h0000_C0E8, 1'b1, 1'b0, pat(32'h0000_C0E8), "R8");
    load(32'h0000_80E0, 1'b0, 1'b1, pat(32'h0000_80E0), "R8");
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; two_phase = 1'b0; req_addr = 32'h0000_1044;
    @(negedge clk);
    check("R3", "first hit", {30'b0, rsp_valid, rsp_hit}, 32'd3);
    check("R3", "first data", rsp_rdata, pat(32'h0000_1044));
    check("R3", "accept while responding", {31'b0, stall}, 32'd0);
    req_addr = 32'h0000_105C;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3", "second hit", {30'b0, rsp_valid, rsp_hit}, 32'd3);
    check("R3", "second data", rsp_rdata, pat(32'h0000_105C));
  endtask

  initial begin
    rst_n = 1'b0; two_phase = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; fill_valid = 1'b0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_basic_loads();
    test_stores();
    test_round_robin();
    test_back_to_back();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule